// File: doc/BRIEF.md
# Memory Bit-Field Operation Unit

This unit carries out one bit-field operation at a time on a byte-addressed, big-endian memory. The caller supplies a base byte address, a signed bit offset measured from the most significant bit of that byte, a 5-bit length code and, for insertion, a source value. Seven operations are available: zero-extending extract, sign-extending extract, insert, invert, clear, set, and find-first-one.

The unit works out which bytes hold the field, fetches them one at a time through a byte-wide memory port that returns data one cycle after the request, and evaluates the field inside a five-byte window. Operations that change the field then write the covering bytes back. When the operation is complete the unit raises `done` for one cycle. It presents a 32-bit result and the N and Z flag values, and holds them until the next operation starts.

Operation codes on `op`: 0 zero-extending extract, 1 sign-extending extract, 2 insert, 3 invert, 4 clear, 5 set, 6 find-first-one, 7 acts as code 0.

Top module: `bitfield_unit`

## Requirements
- R1: A length code of 0 gives a 32-bit field. Any other code c gives a field of c bits.
- R2: The first byte touched is base + floor(offset/8), and the starting bit is offset mod 8, taken as a non-negative value. Field bit 0 is the bit at that position counted from the MSB of that byte, and later field bits run toward the LSB and then into higher addresses.
- R3: Each operation reads exactly ((offset mod 8) + length - 1)/8 + 1 bytes, so never more than 5. Each covering byte is read once, in ascending address order.
- R4: Code 0 returns the field zero-extended to 32 bits. Code 1 returns it sign-extended. Code 7 behaves like code 0.
- R5: Insert (code 2) replaces the field with the low `length` bits of `src_value`, placing the source's bit length-1 at field bit 0. Its N and Z flags describe that inserted value.
- R6: Invert, clear and set (codes 3, 4, 5) write the field back inverted, all zeros or all ones. Insert and these three return the old field zero-extended, and for codes 3 to 5 the flags describe the old field.
- R7: Find-first-one (code 6) returns the original signed offset plus the index of the first 1 bit in the field. If the field is all zeros, it returns the offset plus the length.
- R8: Z is 1 exactly when the field value the flags describe is all zeros. N equals field bit 0 of that value.
- R9: A modifying operation reads every covering byte before it writes any byte, and it writes exactly the bytes it read. Codes 0, 1, 6 and 7 write nothing.
- R10: `start` is accepted only while `busy` is low. `busy` then stays high until `done`, which lasts one cycle. A `start` raised while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 3 | Operation code |
| base_addr | input | AW | Base byte address |
| bit_offset | input | 32 | Signed bit offset from base |
| len_code | input | 5 | Field length code, 0 means 32 |
| src_value | input | 32 | Value to insert |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Operation result |
| flag_n | output | 1 | N flag value |
| flag_z | output | 1 | Z flag value |
| mem_addr | output | AW | Memory byte address |
| mem_rd | output | 1 | Read request, data expected next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |

## Verification
A corrupted byte counter or window index shows up at the ports as a wrong number of read or write strobes, or as a memory image that differs from the model right after `done` — including bytes beyond the span. Either appears within the same operation. A wrong offset split or mask shows up in `result` and the flags at the first `done`, and this is most likely with negative offsets and with fields that cross into a fifth byte. A sequencer that slips its ordering issues a read after a write, or a write on a non-modifying code. The bound checker flags either case in the cycle it happens.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;

    localparam int WIN_BYTES = 5;
    localparam int WIN_BITS  = 8 * WIN_BYTES;
    localparam int DATA_W    = 32;

    typedef enum logic [2:0] {
        OP_EXTU = 3'd0,
        OP_EXTS = 3'd1,
        OP_INS  = 3'd2,
        OP_CHG  = 3'd3,
        OP_CLR  = 3'd4,
        OP_SET  = 3'd5,
        OP_FFO  = 3'd6,
        OP_RSV  = 3'd7
    } bf_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              n;
        logic              z;
    } bf_result_t;

    function automatic logic op_writes(bf_op_e o);
        return (o == OP_INS) || (o == OP_CHG) || (o == OP_CLR) || (o == OP_SET);
    endfunction

    function automatic logic [5:0] decode_len(logic [4:0] code);
        return (code == 5'd0) ? 6'd32 : {1'b0, code};
    endfunction

    // Leading zero count of a 32-bit value (32 when zero).
    function automatic logic [5:0] lead_zeros(logic [DATA_W-1:0] v);
        logic [5:0] cnt;
        cnt = 6'd32;
        for (int i = 0; i < DATA_W; i++) begin
            if (v[i]) cnt = 6'(31 - i);
        end
        return cnt;
    endfunction

endpackage

// File: rtl/bitfield_addr_gen.sv
module bitfield_addr_gen
    import bitfield_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0]     base,
    input  logic signed [31:0] offset,
    input  logic [4:0]        len_code,
    output logic [AW-1:0]     byte_addr,
    output logic [2:0]        bit_pos,
    output logic [5:0]        len,
    output logic [2:0]        last_idx
);
    // Arithmetic shift gives the floor of offset/8; the low bits are the
    // non-negative remainder.
    always_comb begin
        byte_addr = AW'($unsigned(32'(base)) + $unsigned(offset >>> 3));
        bit_pos   = offset[2:0];
        len       = decode_len(len_code);
        last_idx  = 3'((7'(bit_pos) + 7'(len) - 7'd1) >> 3);
    end
endmodule

// File: rtl/bitfield_field_alu.sv
module bitfield_field_alu
    import bitfield_pkg::*;
(
    input  logic [WIN_BITS-1:0] win,
    input  logic [2:0]          bit_pos,
    input  logic [5:0]          len,
    input  bf_op_e              op,
    input  logic [DATA_W-1:0]   src,
    input  logic [DATA_W-1:0]   offset,
    output logic [WIN_BITS-1:0] new_win,
    output bf_result_t          res
);
    logic [WIN_BITS-1:0] mask;
    logic [WIN_BITS-1:0] ins_lj;
    logic [WIN_BITS-1:0] ins_win;
    logic [DATA_W-1:0]   old_top;
    logic [DATA_W-1:0]   ins_top;
    logic [DATA_W-1:0]   flag_src;
    logic signed [DATA_W-1:0] old_signed;
    logic [5:0]          rshift;

    always_comb begin
        rshift     = 6'd32 - len;
        mask       = (~({WIN_BITS{1'b1}} >> len)) >> bit_pos;
        old_top    = 32'(((win & mask) << bit_pos) >> 8);
        old_signed = old_top;
        ins_lj     = {src, 8'h00} << rshift;
        ins_win    = ins_lj >> bit_pos;
        ins_top    = 32'(ins_lj >> 8);

        unique case (op)
            OP_INS:  new_win = (win & ~mask) | (ins_win & mask);
            OP_CHG:  new_win = win ^ mask;
            OP_CLR:  new_win = win & ~mask;
            OP_SET:  new_win = win | mask;
            default: new_win = win;
        endcase

        flag_src = (op == OP_INS) ? ins_top : old_top;
        res.n    = flag_src[DATA_W-1];
        res.z    = (flag_src == '0);

        unique case (op)
            OP_EXTS: res.value = 32'(old_signed >>> rshift);
            OP_FFO:  res.value = offset + 32'((old_top == '0) ? len : lead_zeros(old_top));
            default: res.value = old_top >> rshift;
        endcase
    end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bitfield_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [AW-1:0] base_addr,
    input  logic [31:0]   bit_offset,
    input  logic [4:0]    len_code,
    input  logic [31:0]   src_value,
    output logic          busy,
    output logic          done,
    output logic [31:0]   result,
    output logic          flag_n,
    output logic          flag_z,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);
    typedef enum logic [2:0] {
        S_IDLE, S_READ, S_DRAIN, S_EVAL, S_WRITE, S_DONE
    } state_e;

    state_e              state;
    bf_op_e              op_q;
    logic [31:0]         src_q;
    logic [31:0]         off_q;
    logic [AW-1:0]       addr_q;
    logic [2:0]          bitpos_q;
    logic [5:0]          len_q;
    logic [2:0]          last_q;
    logic [2:0]          cnt;
    logic                pend;
    logic [2:0]          pidx;
    logic [WIN_BITS-1:0] win_q;
    bf_result_t          res_q;

    logic [AW-1:0]       ag_addr;
    logic [2:0]          ag_bitpos;
    logic [5:0]          ag_len;
    logic [2:0]          ag_last;
    logic [WIN_BITS-1:0] alu_win;
    bf_result_t          alu_res;

    bitfield_addr_gen #(.AW(AW)) u_addr (
        .base      (base_addr),
        .offset    (bit_offset),
        .len_code  (len_code),
        .byte_addr (ag_addr),
        .bit_pos   (ag_bitpos),
        .len       (ag_len),
        .last_idx  (ag_last)
    );

    bitfield_field_alu u_alu (
        .win     (win_q),
        .bit_pos (bitpos_q),
        .len     (len_q),
        .op      (op_q),
        .src     (src_q),
        .offset  (off_q),
        .new_win (alu_win),
        .res     (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            op_q     <= OP_EXTU;
            src_q    <= '0;
            off_q    <= '0;
            addr_q   <= '0;
            bitpos_q <= '0;
            len_q    <= '0;
            last_q   <= '0;
            cnt      <= '0;
            pend     <= 1'b0;
            pidx     <= '0;
            win_q    <= '0;
            res_q    <= '0;
        end else begin
            pend <= (state == S_READ);
            pidx <= cnt;
            if (pend) begin
                for (int i = 0; i < WIN_BYTES; i++) begin
                    if (pidx == 3'(i)) win_q[8*(WIN_BYTES-1-i) +: 8] <= mem_rdata;
                end
            end
            unique case (state)
                S_IDLE: if (start) begin
                    op_q     <= bf_op_e'(op);
                    src_q    <= src_value;
                    off_q    <= bit_offset;
                    addr_q   <= ag_addr;
                    bitpos_q <= ag_bitpos;
                    len_q    <= ag_len;
                    last_q   <= ag_last;
                    cnt      <= '0;
                    win_q    <= '0;
                    state    <= S_READ;
                end
                S_READ: begin
                    cnt <= cnt + 3'd1;
                    if (cnt == last_q) state <= S_DRAIN;
                end
                S_DRAIN: state <= S_EVAL;
                S_EVAL: begin
                    res_q <= alu_res;
                    win_q <= alu_win;
                    cnt   <= '0;
                    state <= op_writes(op_q) ? S_WRITE : S_DONE;
                end
                S_WRITE: begin
                    cnt <= cnt + 3'd1;
                    if (cnt == last_q) state <= S_DONE;
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_wdata = '0;
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (cnt == 3'(i)) mem_wdata = win_q[8*(WIN_BYTES-1-i) +: 8];
        end
    end

    assign mem_rd   = (state == S_READ);
    assign mem_wr   = (state == S_WRITE);
    assign mem_addr = addr_q + AW'(cnt);
    assign busy     = (state != S_IDLE);
    assign done     = (state == S_DONE);
    assign result   = res_q.value;
    assign flag_n   = res_q.n;
    assign flag_z   = res_q.z;

endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [2:0] op,
    input logic       busy,
    input logic       done,
    input logic       mem_rd,
    input logic       mem_wr
);
    logic       wrote_seen;
    logic       modify_op;
    logic [3:0] rd_cnt;
    logic [3:0] wr_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wrote_seen <= 1'b0;
            modify_op  <= 1'b0;
            rd_cnt     <= '0;
            wr_cnt     <= '0;
        end else if (start && !busy) begin
            wrote_seen <= 1'b0;
            modify_op  <= (op >= 3'd2) && (op <= 3'd5);
            rd_cnt     <= '0;
            wr_cnt     <= '0;
        end else begin
            if (mem_rd) rd_cnt <= rd_cnt + 4'd1;
            if (mem_wr) begin
                wr_cnt     <= wr_cnt + 4'd1;
                wrote_seen <= 1'b1;
            end
        end
    end

    // R9
    no_read_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !wrote_seen);
    // R9
    write_only_modify_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> modify_op);
    // R9
    read_write_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    // R3
    read_span_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (rd_cnt < 4'd5));
    // R9
    write_count_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (wr_cnt == 4'd0 || wr_cnt == rd_cnt));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !mem_wr && !done));

endmodule

bind bitfield_unit bitfield_unit_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op     (op),
    .busy   (busy),
    .done   (done),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr)
);

// File: tb/bitfield_unit_test.sv
`timescale 1ns/1ps
module bitfield_unit_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    op = '0;
    logic [AW-1:0] base_addr = '0;
    logic [31:0]   bit_offset = '0;
    logic [4:0]    len_code = '0;
    logic [31:0]   src_value = '0;
    logic          busy, done, flag_n, flag_z, mem_rd, mem_wr;
    logic [31:0]   result;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;

    logic [7:0] mem     [256];
    logic [7:0] exp_mem [256];

    int errors = 0;
    int checks = 0;
    int done_cnt = 0;
    int rd_seen = 0;
    int wr_seen = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] val;
        logic        n;
        logic        z;
        int          rd;
        int          wr;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    bitfield_unit #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .base_addr(base_addr),
        .bit_offset(bit_offset), .len_code(len_code), .src_value(src_value),
        .busy(busy), .done(done), .result(result), .flag_n(flag_n), .flag_z(flag_z),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Byte memory: read data one cycle after the request.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    always @(posedge clk) begin
        if (start && !busy) begin
            rd_seen = 0;
            wr_seen = 0;
        end else begin
            if (mem_rd) rd_seen++;
            if (mem_wr) wr_seen++;
        end
    end

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pop and compare on each completion.
    always @(negedge clk) begin
        if (!rst && done) begin
            exp_t e;
            int bad;
            if (sb.size() == 0) begin
                check("R10", "unexpected done", 1, 0);
            end else begin
                e = sb.pop_front();
                check(e.tag, "result", result, e.val);
                check(e.tag, "flag_n", flag_n, e.n);
                check(e.tag, "flag_z", flag_z, e.z);
                check({e.tag, "/R3"}, "bytes read", rd_seen, e.rd);
                check({e.tag, "/R9"}, "bytes written", wr_seen, e.wr);
                bad = 0;
                for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
                check({e.tag, "/R9"}, "memory bytes differing", bad, 0);
            end
            done_cnt++;
        end
    end

    function automatic int floor8(longint p);
        return (p >= 0) ? int'(p / 8) : -int'((-p + 7) / 8);
    endfunction

    // Bit-by-bit reference model; updates exp_mem and pushes the expectation.
    task automatic expect_op(input int o, input int base, input int off, input int lc,
                             input logic [31:0] src, input string tag);
        int len, first, last, a, b;
        longint p;
        logic [63:0] fld;
        logic [31:0] srcm;
        logic bitv, nb;
        int ffo;
        exp_t e;
        len = (lc == 0) ? 32 : lc;
        fld = 0;
        ffo = -1;
        first = floor8(off);
        last  = floor8(longint'(off) + len - 1);
        for (int i = 0; i < len; i++) begin
            p = longint'(off) + i;
            a = base + floor8(p);
            b = int'(p - 64'(floor8(p)) * 8);
            bitv = exp_mem[a[7:0]][7 - b];
            fld = (fld << 1) | 64'(bitv);
            if (bitv && ffo < 0) ffo = i;
            case (o)
                2: nb = src[len - 1 - i];
                3: nb = ~bitv;
                4: nb = 1'b0;
                5: nb = 1'b1;
                default: nb = bitv;
            endcase
            exp_mem[a[7:0]][7 - b] = nb;
        end
        srcm = (len == 32) ? src : (src & ((32'd1 << len) - 1));
        e.tag = tag;
        e.rd  = last - first + 1;
        e.wr  = (o >= 2 && o <= 5) ? e.rd : 0;
        if (o == 2) begin
            e.n = src[len - 1];
            e.z = (srcm == 0);
        end else begin
            e.n = fld[len - 1];
            e.z = (fld == 0);
        end
        case (o)
            1: e.val = (fld[len - 1]) ? 32'(fld | ~((64'd1 << len) - 1)) : 32'(fld);
            6: e.val = 32'(off + ((ffo < 0) ? len : ffo));
            default: e.val = 32'(fld);
        endcase
        sb.push_back(e);
    endtask

    task automatic run_op(input int o, input int base, input int off, input int lc,
                          input logic [31:0] src, input string tag, input bit poke_busy);
        int target;
        expect_op(o, base, off, lc, src, tag);
        target = done_cnt + 1;
        @(negedge clk);
        op = 3'(o); base_addr = AW'(base); bit_offset = off; len_code = 5'(lc);
        src_value = src; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            @(negedge clk);
            op = 3'd5; base_addr = AW'(10); bit_offset = 0; len_code = 5'd8; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (done_cnt >= target);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = (i >= 200 && i < 212) ? 8'h00 : 8'((i * 37 + 11) ^ (i >> 2));
            exp_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10", "reset busy", busy, 0);
        check("R10", "reset done", done, 0);
        check("R9", "reset mem_rd/mem_wr", {mem_rd, mem_wr}, 0);

        run_op(0, 100, 0, 8, 0, "R2 extu byte", 0);
        run_op(0, 100, 5, 0, 0, "R1 extu len32 5 bytes", 0);
        run_op(1, 100, -3, 6, 0, "R4 exts negative offset", 0);
        run_op(1, 120, -17, 12, 0, "R4 exts", 0);
        run_op(2, 60, 13, 20, 32'hFFFA_BCDE, "R5 insert", 0);
        run_op(0, 60, 13, 20, 0, "R5 readback", 0);
        run_op(2, 70, 2, 1, 32'h0000_0000, "R5 insert zero", 0);
        run_op(3, 80, 7, 9, 0, "R6 invert", 0);
        run_op(4, 90, -9, 16, 0, "R6 clear", 0);
        run_op(5, 140, 31, 0, 0, "R6 set len32", 0);
        run_op(0, 140, 31, 0, 0, "R6 set readback", 0);
        run_op(6, 100, 3, 10, 0, "R7 ffo", 0);
        run_op(6, 205, -6, 20, 0, "R7 ffo all zero", 0);
        run_op(6, 205, 100, 31, 0, "R8 ffo first bit", 0);
        run_op(7, 110, 11, 13, 0, "R4 code7", 0);
        run_op(1, 130, -40, 32, 0, "R10 start while busy", 1);
        repeat (12) begin
            @(negedge clk);
            check("R10", "no extra op busy", busy, 0);
        end
        check("R10", "scoreboard empty", sb.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule